// File: doc/BRIEF.md
# Zero-Phase-Matched Clock Switch

This block chooses which of several candidate clocks (an RF-derived clock or one of the local references) drives the reference input of a downstream PLL. A change of source is requested with a one-cycle strobe and a source index. The block then waits until the rising edges of the current and the requested clock coincide, and changes the multiplexer select only while both clocks are low. The output therefore changes source without a phase step and without a runt pulse.

All control logic runs on a fast sampling clock. Each candidate clock is brought into that domain through a synchronizer, and the rising edges are compared there. A frequency monitor outside the block supplies one live flag per source, synchronous to the sampling clock. A request for a dead source is refused. A pending switch waits for alignment for as long as it takes, and is dropped only when its target dies. If the active source dies, the block falls back at once to the source that was in use before it. This fallback does not wait for a phase match.

Top module: `zpm_clock_switch`

## Requirements
- R1: A request whose index names a source whose live flag is 0 is refused: busy_o stays 0 and cur_sel_o keeps its value.
- R2: A switch between two live sources completes only after the rising edges of the current and the target clock have appeared, after their synchronizers, in the same or in adjacent clk_i samples. At completion, the last rising edges of the old and the new clock lie no more than two clk_i periods apart.
- R3: While a phase-matched switch is pending, busy_o is 1 and no timeout ends the wait. A pending switch is cancelled on the first clk_i edge at which its target's live flag is 0. cur_sel_o then keeps its value.
- R4: When the live flag of the active source is 0 and the previously used source is live, cur_sel_o takes the previous source's index at the next clk_i edge, without any phase match. Any pending switch is dropped.
- R5: A source that died and was left by fallback can be selected again with a normal request, which completes through the phase-matched path of R2.
- R6: The multiplexer select changes on the phase-matched path only while the synchronized current and target clocks are both low. With source half periods of at least 100 ns, ref_clk_o shows no high or low phase shorter than 60 ns on that path.
- R7: A request that arrives while a switch is pending replaces the pending target.
- R8: A request whose index equals cur_sel_o cancels any pending switch and does not change cur_sel_o.
- R9: After reset, cur_sel_o is 0, the previous source is also 0, and busy_o and done_o are 0.
- R10: done_o is a one-cycle pulse in the cycle after each change of cur_sel_o, whether the change came from a phase-matched switch or from a fallback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock for all control logic |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| src_clk_i | input | N_SRC | Candidate clocks, asynchronous to clk_i |
| src_live_i | input | N_SRC | Live flag per source, synchronous to clk_i |
| req_i | input | 1 | One-cycle switch request strobe |
| req_sel_i | input | SEL_W | Index of the requested source |
| ref_clk_o | output | 1 | Selected reference clock |
| cur_sel_o | output | SEL_W | Index of the source driving ref_clk_o |
| busy_o | output | 1 | A phase-matched switch is pending |
| done_o | output | 1 | One-cycle pulse after cur_sel_o changes |

## Verification
On every cycle, the assertions check these rules: a refused request leaves the selection untouched, the low-wait state is entered only after a detected coincidence, the select moves only while both sampled clocks are low, a dead target cancels the wait, a dead active source forces the fallback one cycle later, and done_o follows every change of selection.

Other properties need real waveforms, so only the bench scenarios can show them:
- the alignment of the actual rising edges at changeover, across all ordered pairs of three clocks with different phases and periods;
- a wait that never ends on two clocks in antiphase;
- the absence of runt pulses on ref_clk_o.

// File: rtl/zpm_pkg.sv
`timescale 1ns/1ps
package zpm_pkg;
    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_MATCH = 2'd1,
        SW_LOW   = 2'd2
    } sw_state_e;
endpackage

// File: rtl/zpm_sync.sv
`timescale 1ns/1ps
module zpm_sync #(
    parameter int N_SRC  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [N_SRC-1:0] async_i,
    output logic [N_SRC-1:0] sync_o
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) chain_q <= '0;
            else          chain_q <= {chain_q[STAGES-2:0], async_i[g]};
        end
        assign sync_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/zpm_edge_match.sv
`timescale 1ns/1ps
module zpm_edge_match #(
    parameter int N_SRC = 4,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [N_SRC-1:0] smp_i,
    input  logic [SEL_W-1:0] cur_i,
    input  logic [SEL_W-1:0] tgt_i,
    output logic             match_o,
    output logic             both_low_o
);
    typedef struct packed {
        logic [N_SRC-1:0] prev;
        logic [N_SRC-1:0] rise_dly;
    } em_regs_t;

    em_regs_t em_d, em_q;
    logic [N_SRC-1:0] rise;

    always_comb begin
        rise          = smp_i & ~em_q.prev;
        em_d.prev     = smp_i;
        em_d.rise_dly = rise;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) em_q <= '0;
        else          em_q <= em_d;
    end

    // coincidence: both rises in the same sample, or one sample apart
    assign match_o = (rise[cur_i] && (rise[tgt_i] || em_q.rise_dly[tgt_i]))
                   || (rise[tgt_i] && em_q.rise_dly[cur_i]);
    assign both_low_o = !smp_i[cur_i] && !smp_i[tgt_i];

    // R2: a reported match always coincides with a fresh sampled rise
    a_r2_match_on_rise: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        match_o |-> (smp_i[cur_i] && !em_q.prev[cur_i]) || (smp_i[tgt_i] && !em_q.prev[tgt_i]));
endmodule

// File: rtl/zpm_ctrl.sv
`timescale 1ns/1ps
module zpm_ctrl
    import zpm_pkg::*;
#(
    parameter int N_SRC = 4,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [N_SRC-1:0] live_i,
    input  logic             req_i,
    input  logic [SEL_W-1:0] req_sel_i,
    input  logic             match_i,
    input  logic             both_low_i,
    output logic [SEL_W-1:0] cur_o,
    output logic [SEL_W-1:0] tgt_o,
    output logic             busy_o,
    output logic             done_o
);
    typedef struct packed {
        sw_state_e        state;
        logic [SEL_W-1:0] cur;
        logic [SEL_W-1:0] tgt;
        logic [SEL_W-1:0] alt;
        logic             done;
    } ctl_regs_t;

    ctl_regs_t ct_d, ct_q;
    logic req_valid;

    always_comb begin
        req_valid = int'(req_sel_i) < N_SRC;
        ct_d      = ct_q;
        ct_d.done = 1'b0;
        if (!live_i[ct_q.cur] && live_i[ct_q.alt] && ct_q.alt != ct_q.cur) begin
            ct_d.cur   = ct_q.alt;
            ct_d.alt   = ct_q.cur;
            ct_d.state = SW_IDLE;
            ct_d.done  = 1'b1;
        end else if (req_i) begin
            if (req_sel_i == ct_q.cur) begin
                ct_d.state = SW_IDLE;
            end else if (req_valid && live_i[req_sel_i]) begin
                ct_d.tgt   = req_sel_i;
                ct_d.state = SW_MATCH;
            end
        end else begin
            unique case (ct_q.state)
                SW_MATCH: begin
                    if (!live_i[ct_q.tgt]) ct_d.state = SW_IDLE;
                    else if (match_i)      ct_d.state = SW_LOW;
                end
                SW_LOW: begin
                    if (!live_i[ct_q.tgt]) begin
                        ct_d.state = SW_IDLE;
                    end else if (both_low_i) begin
                        ct_d.cur   = ct_q.tgt;
                        ct_d.alt   = ct_q.cur;
                        ct_d.state = SW_IDLE;
                        ct_d.done  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            ct_q       <= '0;
            ct_q.state <= SW_IDLE;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign cur_o  = ct_q.cur;
    assign tgt_o  = ct_q.tgt;
    assign busy_o = ct_q.state != SW_IDLE;
    assign done_o = ct_q.done;

    // R1: refused request into a dead source leaves everything idle
    a_r1_refuse_dead: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ct_q.state == SW_IDLE && req_i && req_sel_i != ct_q.cur && !live_i[req_sel_i]
         && live_i[ct_q.cur]) |=> (ct_q.state == SW_IDLE && $stable(ct_q.cur)));
    // R2: low-wait is reached only through a detected coincidence
    a_r2_match_first: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ct_q.state == SW_LOW) |-> ($past(ct_q.state) == SW_LOW || $past(match_i)));
    // R3: a dead target drops the pending switch
    a_r3_cancel_dead: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ct_q.state != SW_IDLE && !live_i[ct_q.tgt] && !req_i) |=> (ct_q.state == SW_IDLE));
    // R4: dead active source falls back in one cycle
    a_r4_fallback: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!live_i[ct_q.cur] && live_i[ct_q.alt] && ct_q.alt != ct_q.cur)
        |=> (ct_q.cur == $past(ct_q.alt)));
    // R6: matched switch moves the select only with both sampled clocks low
    a_r6_switch_low: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($past(ct_q.state) == SW_LOW && ct_q.cur != $past(ct_q.cur)) |-> $past(both_low_i));
    // R10: every selection change is followed by done
    a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ct_q.cur != $past(ct_q.cur)) |-> ct_q.done);
endmodule

// File: rtl/zpm_clock_switch.sv
`timescale 1ns/1ps
module zpm_clock_switch #(
    parameter int N_SRC       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(N_SRC)
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [N_SRC-1:0] src_clk_i,
    input  logic [N_SRC-1:0] src_live_i,
    input  logic             req_i,
    input  logic [SEL_W-1:0] req_sel_i,
    output logic             ref_clk_o,
    output logic [SEL_W-1:0] cur_sel_o,
    output logic             busy_o,
    output logic             done_o
);
    logic [N_SRC-1:0] smp;
    logic [SEL_W-1:0] cur, tgt;
    logic             match, both_low;

    zpm_sync #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) sync_i (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .async_i(src_clk_i), .sync_o(smp)
    );

    zpm_edge_match #(.N_SRC(N_SRC)) match_i (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .smp_i(smp), .cur_i(cur), .tgt_i(tgt),
        .match_o(match), .both_low_o(both_low)
    );

    zpm_ctrl #(.N_SRC(N_SRC)) ctrl_i (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .live_i(src_live_i), .req_i(req_i),
        .req_sel_i(req_sel_i), .match_i(match), .both_low_i(both_low),
        .cur_o(cur), .tgt_o(tgt), .busy_o(busy_o), .done_o(done_o)
    );

    assign ref_clk_o = src_clk_i[cur];
    assign cur_sel_o = cur;
endmodule

// File: tb/zpm_clock_switch_tb_top.sv
`timescale 1ns/1ps
module zpm_clock_switch_tb_top;
    localparam int N = 4;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [N-1:0] src_clk = '0;
    logic [N-1:0] live = '1;
    logic       req = 1'b0;
    logic [1:0] req_sel = '0;
    logic       ref_clk, busy, done;
    logic [1:0] cur_sel;

    int n_chk = 0, n_fail = 0, runts = 0;
    bit mon_en = 1'b0;
    realtime t_rise[N];
    realtime t_edge = -1.0;

    zpm_clock_switch #(.N_SRC(N)) dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .src_clk_i(src_clk), .src_live_i(live),
        .req_i(req), .req_sel_i(req_sel), .ref_clk_o(ref_clk), .cur_sel_o(cur_sel),
        .busy_o(busy), .done_o(done)
    );

    always #5 clk = ~clk;
    // source clocks: 0 and 1 nearly aligned, 2 in antiphase to both, 3 slower and drifting
    initial begin #1;   forever #100 src_clk[0] = ~src_clk[0]; end
    initial begin #4;   forever #100 src_clk[1] = ~src_clk[1]; end
    initial begin #101; forever #100 src_clk[2] = ~src_clk[2]; end
    initial begin #2;   forever #105 src_clk[3] = ~src_clk[3]; end
    always @(posedge src_clk[0]) t_rise[0] = $realtime;
    always @(posedge src_clk[1]) t_rise[1] = $realtime;
    always @(posedge src_clk[2]) t_rise[2] = $realtime;
    always @(posedge src_clk[3]) t_rise[3] = $realtime;

    // R6 runt monitor on the output
    always @(ref_clk) begin
        if (mon_en && t_edge >= 0.0 && ($realtime - t_edge) < 60.0) runts++;
        t_edge = $realtime;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input int sel);
        @(negedge clk); req = 1'b1; req_sel = 2'(sel);
        @(negedge clk); req = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    task automatic matched_switch(input int from, input int to, input string tag);
        bit seen;
        int gap;
        pulse_req(to);
        wait_done(seen);
        chk(seen, {tag, " done pulse"}, int'(seen), 1);
        chk(cur_sel == 2'(to), {tag, " selection"}, int'(cur_sel), to);
        gap = int'(t_rise[from] > t_rise[to] ? t_rise[from] - t_rise[to] : t_rise[to] - t_rise[from]);
        chk(gap <= 20, {tag, " edge gap ns"}, gap, 20);
        @(negedge clk);
        chk(!done, {tag, " done one cycle R10"}, int'(done), 0);
    endtask

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(cur_sel == 2'd0 && !busy && !done, "R9 reset", int'(cur_sel) + int'(busy) + int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        mon_en = 1'b1;

        // R8 request of the active source does nothing
        pulse_req(0);
        chk(!busy && cur_sel == 2'd0, "R8 same source", int'(busy), 0);

        // R1 dead target refused
        live[2] = 1'b0;
        pulse_req(2);
        chk(!busy, "R1 busy", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk(cur_sel == 2'd0, "R1 selection", int'(cur_sel), 0);
        live[2] = 1'b1;

        // R2/R10 sweep over all ordered pairs of sources 0, 1, 3
        matched_switch(0, 1, "R2 0->1");
        matched_switch(1, 3, "R2 1->3");
        matched_switch(3, 0, "R2 3->0");
        matched_switch(0, 3, "R2 0->3");
        matched_switch(3, 1, "R2 3->1");
        matched_switch(1, 0, "R2 1->0");

        // R3 antiphase target: wait never ends, then cancelled by death
        pulse_req(2);
        repeat (3000) @(negedge clk);
        chk(busy, "R3 still pending", int'(busy), 1);
        chk(cur_sel == 2'd0, "R3 selection held", int'(cur_sel), 0);
        live[2] = 1'b0;
        @(negedge clk);
        chk(!busy, "R3 cancel", int'(busy), 0);
        chk(cur_sel == 2'd0, "R3 selection after cancel", int'(cur_sel), 0);
        live[2] = 1'b1;

        // R8 request of active source cancels pending
        pulse_req(2);
        chk(busy, "R8 pending set", int'(busy), 1);
        pulse_req(0);
        chk(!busy && cur_sel == 2'd0, "R8 cancel pending", int'(busy), 0);

        // R7 replacement of pending target
        pulse_req(2);
        repeat (50) @(negedge clk);
        matched_switch(0, 3, "R7 replace 2 by 3");

        // R4 fallback from dead 3 to 0, no phase wait
        mon_en = 1'b0;
        @(negedge clk); live[3] = 1'b0;
        @(negedge clk);
        chk(cur_sel == 2'd0, "R4 fallback selection", int'(cur_sel), 0);
        chk(done, "R4 fallback done R10", int'(done), 1);
        repeat (40) @(negedge clk);
        t_edge = -1.0;
        mon_en = 1'b1;

        // R5 revived source returns through phase match
        live[3] = 1'b1;
        pulse_req(3);
        chk(busy, "R5 waits for match", int'(busy), 1);
        wait_done(seen);
        chk(seen && cur_sel == 2'd3, "R5 return", int'(cur_sel), 3);
        chk((t_rise[3] > t_rise[0] ? t_rise[3] - t_rise[0] : t_rise[0] - t_rise[3]) <= 20.0,
            "R5 edge gap", int'(t_rise[3]), int'(t_rise[0]));

        repeat (50) @(negedge clk);
        chk(runts == 0, "R6 runt pulses", runts, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule